// File: doc/BRIEF.md
# ADC Conversion Mode Controller

This block sits between a register interface and a converter core. It keeps an 8-bit configuration byte and a 16-bit result word, and it decides when the core converts. It runs in one of two modes. In continuous mode each finished sample is stored and the next conversion starts at once. In single-shot mode one conversion runs for each request, and then the core is powered down.

The configuration byte is written through a strobe with data. The core takes a one-cycle start pulse and answers with a done pulse and a 12-bit two's-complement sample. The block drives the gain code and a power-enable to the analog side. A reset request puts all registers back to their defaults, including while a conversion is running.

Top module: `conv_mode_ctrl`

## Requirements
- R1: After reset the configuration byte reads 0x80, gain_sel is 0 and pwr_en is 0.
- R2: Configuration byte layout: bit 7 is start/busy, bit 4 is the single-shot select (1 = single-shot), and bits 1:0 are the gain code (00, 01, 10, 11 for gain 1, 2, 4, 8), which also drives gain_sel. Bits 6:5 and 3:2 always read 0, whatever is written.
- R3: In continuous mode every done pulse stores the sample, and a new start pulse follows in the next cycle.
- R4: In single-shot mode, a write with bit 7 = 1 starts exactly one conversion, and a write with bit 7 = 0 starts none. pwr_en is 1 from the start until the result is stored.
- R5: In single-shot mode, a write with bit 7 = 1 while a conversion is running adds no start pulse.
- R6: Bit 7 reads pwr_en in single-shot mode and always reads 1 in continuous mode.
- R7: A switch from continuous to single-shot lets the running conversion finish. The block then stores its result, reads bit 7 as 0, drops pwr_en and issues no further start. This also holds when the switch arrives in the same cycle as done.
- R8: The stored result is the 12-bit sample right-justified, with bits 15:12 copies of sample bit 11.
- R9: The result reads 0 after reset until the first conversion completes.
- R10: A done pulse while no conversion is pending changes neither the result nor pwr_en.
- R11: The start pulse is exactly one cycle wide.
- R12: A reset request while converting drops pwr_en at the next edge, stores nothing, clears the result and restores the configuration byte to 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst_req | input | 1 | Reset request, same effect as rst |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| core_done | input | 1 | Conversion finished pulse from core |
| core_sample | input | 12 | Two's-complement sample from core |
| core_start | output | 1 | One-cycle conversion start pulse |
| cfg_rdata | output | 8 | Readable configuration byte with live status |
| result | output | 16 | Sign-extended result register |
| gain_sel | output | 2 | Gain code to the amplifier |
| pwr_en | output | 1 | Core power enable |

## Verification
Two events can land in the same cycle: a mode write from continuous to single-shot, and the core's done pulse for the conversion that is running. The bench waits until its stub core raises done and drives the mode write in that same cycle. It then expects the sample to be stored, pwr_en to drop, bit 7 to read 0 and no new start to follow. It also gives a reset request priority over a conversion that is running, and checks that no result from the aborted conversion appears.

// File: rtl/conv_ctrl_pkg.sv
package conv_ctrl_pkg;
  localparam int CFG_W   = 8;
  localparam int BIT_ST  = 7;
  localparam int BIT_SC  = 4;
  localparam int GAIN_W  = 2;
  localparam logic [CFG_W-1:0] CFG_DEFAULT = 8'h80;

  typedef enum logic {SEQ_IDLE, SEQ_CONV} seq_state_t;
endpackage

// File: rtl/cc_cfg_reg.sv
module cc_cfg_reg
  import conv_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr,
  input  logic              wr_single,
  input  logic [GAIN_W-1:0] wr_gain,
  output logic              single_q,
  output logic [GAIN_W-1:0] gain_q,
  output logic              single_eff
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      single_q <= CFG_DEFAULT[BIT_SC];
      gain_q   <= CFG_DEFAULT[GAIN_W-1:0];
    end else if (wr) begin
      single_q <= wr_single;
      gain_q   <= wr_gain;
    end
  end

  // mode seen by the sequencer in the write cycle itself
  always_comb single_eff = wr ? wr_single : single_q;
endmodule

// File: rtl/cc_seq.sv
module cc_seq
  import conv_ctrl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic single_eff,
  input  logic go_req,
  input  logic done,
  output logic busy_q,
  output logic start_q,
  output logic store
);
  seq_state_t state_q;

  always_comb begin
    busy_q = (state_q == SEQ_CONV);
    store  = busy_q && done && !clr;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state_q <= SEQ_IDLE;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (!single_eff || go_req) begin
            state_q <= SEQ_CONV;
            start_q <= 1'b1;
          end
        end
        SEQ_CONV: begin
          if (done) begin
            if (!single_eff) start_q <= 1'b1;
            else             state_q <= SEQ_IDLE;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cc_result.sv
module cc_result #(
  parameter int RAW_W = 12,
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             store,
  input  logic [RAW_W-1:0] sample,
  output logic [RES_W-1:0] result_q
);
  localparam int EXT_W = RES_W - RAW_W;

  always_ff @(posedge clk) begin
    if (rst || clr)  result_q <= '0;
    else if (store)  result_q <= {{EXT_W{sample[RAW_W-1]}}, sample};
  end
endmodule

// File: rtl/conv_mode_ctrl.sv
module conv_mode_ctrl
  import conv_ctrl_pkg::*;
#(
  parameter int RAW_W = 12,
  parameter int RES_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst_req,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              core_done,
  input  logic [RAW_W-1:0]  core_sample,
  output logic              core_start,
  output logic [CFG_W-1:0]  cfg_rdata,
  output logic [RES_W-1:0]  result,
  output logic [GAIN_W-1:0] gain_sel,
  output logic              pwr_en
);
  logic single_q, single_eff, busy, store, go_req;
  logic [GAIN_W-1:0] gain_q;

  always_comb go_req = cfg_wr && cfg_wdata[BIT_ST] && cfg_wdata[BIT_SC];

  cc_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .clr(soft_rst_req), .wr(cfg_wr),
    .wr_single(cfg_wdata[BIT_SC]), .wr_gain(cfg_wdata[GAIN_W-1:0]),
    .single_q(single_q), .gain_q(gain_q), .single_eff(single_eff)
  );

  cc_seq u_seq (
    .clk(clk), .rst(rst), .clr(soft_rst_req), .single_eff(single_eff),
    .go_req(go_req), .done(core_done), .busy_q(busy),
    .start_q(core_start), .store(store)
  );

  cc_result #(.RAW_W(RAW_W), .RES_W(RES_W)) u_res (
    .clk(clk), .rst(rst), .clr(soft_rst_req), .store(store),
    .sample(core_sample), .result_q(result)
  );

  always_comb begin
    cfg_rdata                = '0;
    cfg_rdata[BIT_ST]        = single_q ? busy : 1'b1;
    cfg_rdata[BIT_SC]        = single_q;
    cfg_rdata[GAIN_W-1:0]    = gain_q;
    gain_sel                 = gain_q;
    pwr_en                   = busy;
  end
endmodule

// File: rtl/conv_ctrl_checker.sv
module conv_ctrl_checker (
  input logic        clk,
  input logic        rst,
  input logic        soft_rst_req,
  input logic        cfg_wr,
  input logic        core_done,
  input logic        core_start,
  input logic [7:0]  cfg_rdata,
  input logic [15:0] result,
  input logic        pwr_en
);
  p_start_width_r11: assert property (@(posedge clk) disable iff (rst)
    core_start |=> !core_start);
  p_start_powered_r4: assert property (@(posedge clk) disable iff (rst)
    core_start |-> pwr_en);
  p_cont_status_r6: assert property (@(posedge clk) disable iff (rst)
    !cfg_rdata[4] |-> cfg_rdata[7]);
  p_single_status_r6: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[4] |-> (cfg_rdata[7] == pwr_en));
  p_sign_ext_r8: assert property (@(posedge clk) disable iff (rst)
    result[15:12] == {4{result[11]}});
  p_idle_done_r10: assert property (@(posedge clk) disable iff (rst)
    (!pwr_en && core_done && !soft_rst_req) |=> $stable(result));
  p_cont_restart_r3: assert property (@(posedge clk) disable iff (rst)
    (pwr_en && core_done && !cfg_rdata[4] && !cfg_wr && !soft_rst_req) |=> core_start);
  p_abort_r12: assert property (@(posedge clk) disable iff (rst)
    soft_rst_req |=> (!pwr_en && result == 16'h0 && cfg_rdata == 8'h80));
endmodule

bind conv_mode_ctrl conv_ctrl_checker i_chk (
  .clk(clk), .rst(rst), .soft_rst_req(soft_rst_req), .cfg_wr(cfg_wr),
  .core_done(core_done), .core_start(core_start), .cfg_rdata(cfg_rdata),
  .result(result), .pwr_en(pwr_en)
);

// File: tb/test_conv_mode_ctrl.sv
`timescale 1ns/1ps
module test_conv_mode_ctrl;
  localparam int CONV_LAT = 6;

  logic clk = 0, rst = 1, soft_rst_req = 0, cfg_wr = 0;
  logic [7:0] cfg_wdata = 0;
  logic stub_done = 0, inj_done = 0, core_done;
  logic [11:0] sample_val = 0;
  logic core_start, pwr_en;
  logic [7:0] cfg_rdata;
  logic [15:0] result;
  logic [1:0] gain_sel;
  int cnt = 0, start_cnt = 0, width_err = 0, n_chk = 0, n_fail = 0;
  logic prev_start = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  assign core_done = stub_done | inj_done;

  conv_mode_ctrl i_conv_mode_ctrl (
    .clk(clk), .rst(rst), .soft_rst_req(soft_rst_req), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .core_done(core_done), .core_sample(sample_val),
    .core_start(core_start), .cfg_rdata(cfg_rdata), .result(result),
    .gain_sel(gain_sel), .pwr_en(pwr_en)
  );

  // stub core with fixed conversion time
  always @(posedge clk) begin
    stub_done <= 0;
    if (rst || soft_rst_req) cnt <= 0;
    else if (core_start) cnt <= CONV_LAT;
    else if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) stub_done <= 1;
    end
    if (!rst) begin
      if (core_start) start_cnt <= start_cnt + 1;
      if (core_start && prev_start) width_err <= width_err + 1;
    end
    prev_start <= core_start;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [7:0] d);
    cfg_wr = 1; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic wait_idle(input string req);
    int i;
    for (i = 0; i < 200 && pwr_en; i++) @(negedge clk);
    chk(req, pwr_en, 0);
  endtask

  task automatic wait_result(input logic [15:0] exp, input string req);
    for (int i = 0; i < 200 && result !== exp; i++) @(negedge clk);
    chk(req, result, exp);
  endtask

  task automatic t_reset;
    rst = 1; sample_val = 12'h7FF;
    cyc(3);
    chk("R1 cfg", cfg_rdata, 8'h80);
    chk("R1 gain", gain_sel, 0);
    chk("R1 pwr", pwr_en, 0);
    chk("R9 result", result, 0);
    rst = 0;
    cyc(1);
    chk("R9 result before completion", result, 0);
  endtask

  task automatic t_cont;
    int s;
    wait_result(16'h07FF, "R3 first");
    s = start_cnt;
    sample_val = 12'h800;
    wait_result(16'hF800, "R8 negative");
    sample_val = 12'h123;
    wait_result(16'h0123, "R3 next");
    chk("R3 restarts", (start_cnt - s) >= 2, 1);
  endtask

  task automatic t_gain;
    wr_cfg(8'h6E);
    chk("R2 layout", cfg_rdata, 8'h82);
    chk("R2 gain", gain_sel, 2);
  endtask

  task automatic t_cont_to_single;
    int s;
    for (int i = 0; i < 100 && !core_start; i++) @(negedge clk);
    cyc(2);
    sample_val = 12'hABC;
    wr_cfg(8'h12);
    chk("R7 keeps power", pwr_en, 1);
    chk("R6 busy read", cfg_rdata, 8'h92);
    wait_idle("R7 powers down");
    chk("R7 stored", result, 16'hFABC);
    chk("R6 idle read", cfg_rdata, 8'h12);
    s = start_cnt;
    cyc(20);
    chk("R7 no restart", start_cnt, s);
    wr_cfg(8'h12);
    cyc(10);
    chk("R4 zero write no start", start_cnt, s);
    chk("R4 zero write power", pwr_en, 0);
  endtask

  task automatic t_single;
    int s;
    s = start_cnt;
    sample_val = 12'h055;
    wr_cfg(8'h91);
    chk("R4 power on", pwr_en, 1);
    chk("R6 busy bit", cfg_rdata, 8'h91);
    cyc(2);
    wr_cfg(8'h91);
    wait_idle("R4 completes");
    cyc(2);
    chk("R5 one start", start_cnt, s + 1);
    chk("R4 result", result, 16'h0055);
    chk("R6 done read", cfg_rdata, 8'h11);
  endtask

  task automatic t_idle_done;
    int s;
    s = start_cnt;
    sample_val = 12'h3FF;
    inj_done = 1;
    @(negedge clk);
    inj_done = 0;
    cyc(1);
    chk("R10 result", result, 16'h0055);
    chk("R10 power", pwr_en, 0);
    chk("R10 no start", start_cnt, s);
  endtask

  task automatic t_collision;
    int s;
    sample_val = 12'h7A0;
    wr_cfg(8'h00);
    for (int i = 0; i < 100 && !core_done; i++) @(negedge clk);
    wr_cfg(8'h10);
    chk("R7 same-cycle store", result, 16'h07A0);
    chk("R7 same-cycle power", pwr_en, 0);
    chk("R7 same-cycle read", cfg_rdata, 8'h10);
    s = start_cnt;
    cyc(10);
    chk("R7 same-cycle no start", start_cnt, s);
  endtask

  task automatic t_abort;
    sample_val = 12'h111;
    wr_cfg(8'h90);
    cyc(2);
    soft_rst_req = 1;
    @(negedge clk);
    soft_rst_req = 0;
    chk("R12 power", pwr_en, 0);
    chk("R12 result", result, 0);
    chk("R12 cfg", cfg_rdata, 8'h80);
    cyc(3);
    chk("R9 after abort", result, 0);
    wait_result(16'h0111, "R3 after abort");
  endtask

  initial begin
    t_reset();
    t_cont();
    t_gain();
    t_cont_to_single();
    t_single();
    t_idle_done();
    t_collision();
    t_abort();
    chk("R11 start width", width_err, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule